// File: doc/BRIEF.md
# Descriptor Ring Prefetch and Writeback Engine

This block tracks a circular ring of fixed-size descriptors in host memory and a small on-chip descriptor cache. It keeps the ring base address, the ring length in descriptors, the head index and the tail index. It also keeps its own cache pointer, which marks the next ring slot to prefetch. It splits the cache into unused entries, which have been fetched but not yet consumed, and used entries, which have been consumed and are waiting to be returned. It issues burst read requests that fill free cache slots. It issues burst write requests that return used entries. When a write completes, it advances the head.

Descriptor contents and the actual data movement are outside the block. A DMA agent takes each request over a valid/ready handshake and later reports completion with a one-cycle strobe. A request is raised only from the idle state, and its address and count stay frozen until ready is seen high. A completion strobe counts only after its request has been accepted. There is no buffering at either request port, so stalling ready simply holds the request in place.

Software or a neighbouring state machine drives the rest of the block. It loads the ring configuration, writes the tail, pulses a consume strobe for each descriptor it finishes with, and pulses a writeback kick with an alignment mask.

Top module: `dr_ring_engine`

## Requirements
- R1: When the tail is at or above the cache pointer, the prefetch count is tail minus cache pointer. Otherwise it is ring length minus cache pointer. A fetch therefore never runs past the last ring slot.
- R2: The prefetch count is further capped at the free cache space, which is CACHE_DEPTH minus used minus unused. When the resulting count is zero, no fetch request is raised.
- R3: The fetch address is base plus cache pointer times 16 bytes. When a fetch completes, the cache pointer moves forward by the count and returns to 0 when it reaches the ring length.
- R4: At most one fetch is outstanding. Tail updates during an outstanding fetch raise no second request. A fetch completion strobe with no accepted fetch has no effect.
- R5: The writeback count is every used entry, clipped to ring length minus head. When that clip does not apply and the alignment mask is non-zero, the count is ANDed with the inverted mask.
- R6: The writeback address is base plus head times 16 bytes. On completion, head advances by the count modulo the ring length, and the used count falls by the count.
- R7: After each writeback completes, the engine re-evaluates the writeback count with the last mask. If the count is non-zero it raises another writeback. If it is zero it raises nothing.
- R8: At most one writeback is outstanding. A kick that arrives while a writeback is outstanding is deferred. Its mask replaces the stored mask if it is smaller, and it takes effect in the re-evaluation after completion.
- R9: A consume strobe moves one entry from unused to used. It is ignored when no unused entry exists. The free count always equals CACHE_DEPTH minus used minus unused.
- R10: A configuration load is rejected while any entry is cached or any fetch or writeback is outstanding. A rejected load raises cfg_fault for one cycle, and base, length and head keep their values. Otherwise the load takes effect.
- R11: Asynchronous reset clears everything. A ring_clr pulse empties both cache queues, zeroes the cache pointer and drops any outstanding request. Base, length, tail and head survive ring_clr.
- R12: A request held without ready keeps valid, address and count stable. A completion strobe that arrives before acceptance is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_clr | input | 1 | Synchronous clear of cache queues, cache pointer and outstanding operations |
| cfg_load | input | 1 | Load base, length and head |
| cfg_base | input | ADDR_W | Ring base byte address |
| cfg_len | input | IDX_W+1 | Ring length in descriptors |
| cfg_head | input | IDX_W | Head index to load |
| tail_wr | input | 1 | Tail update strobe |
| tail_val | input | IDX_W | New tail index |
| desc_take | input | 1 | One descriptor consumed |
| wb_kick | input | 1 | Request a writeback of used entries |
| wb_align_mask | input | CNT_W | Writeback rounding mask |
| fetch_req_valid | output | 1 | Fetch request valid |
| fetch_req_ready | input | 1 | Fetch request accepted |
| fetch_req_addr | output | ADDR_W | Fetch byte address |
| fetch_req_cnt | output | CNT_W | Descriptors to fetch |
| fetch_done | input | 1 | Fetch completion strobe |
| wb_req_valid | output | 1 | Writeback request valid |
| wb_req_ready | input | 1 | Writeback request accepted |
| wb_req_addr | output | ADDR_W | Writeback byte address |
| wb_req_cnt | output | CNT_W | Descriptors to write back |
| wb_done | input | 1 | Writeback completion strobe |
| head | output | IDX_W | Current head index |
| free_cnt | output | CNT_W | Free cache slots |
| used_cnt | output | CNT_W | Used cache entries |
| unused_cnt | output | CNT_W | Unused cache entries |
| cfg_fault | output | 1 | One-cycle pulse on a rejected load |

## Verification
The bench builds the engine with its defaults: an 8-entry cache, rings of up to 4096 descriptors, 16-byte descriptors and 48-bit addresses. It programs rings of 10 and 4 descriptors. The 8-entry cache fills before the 10-entry ring is used up, so the free-space cap can be seen. The tail, cache pointer and head all wrap within a handful of transfers. A writeback that starts at index 8 reaches the ring end, which exercises the end-of-ring clip ahead of the alignment rounding.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2
  } xfer_st_e;
endpackage

// File: rtl/dr_occupancy.sv
module dr_occupancy #(
  parameter int CACHE_DEPTH = 8,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             fill,
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic             take,
  input  logic             drain,
  input  logic [CNT_W-1:0] drain_cnt,
  output logic [CNT_W-1:0] used,
  output logic [CNT_W-1:0] unused,
  output logic [CNT_W-1:0] free
);
  logic [CNT_W-1:0] used_q, unused_q;
  logic             take_ok;
  logic [CNT_W-1:0] add_fill, sub_drain;

  assign take_ok   = take && (unused_q != '0);
  assign add_fill  = fill  ? fill_cnt  : '0;
  assign sub_drain = drain ? drain_cnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q   <= '0;
      unused_q <= '0;
    end else if (clr) begin
      used_q   <= '0;
      unused_q <= '0;
    end else begin
      unused_q <= unused_q + add_fill - CNT_W'(take_ok);
      used_q   <= used_q + CNT_W'(take_ok) - sub_drain;
    end
  end

  assign used   = used_q;
  assign unused = unused_q;
  assign free   = CNT_W'(CACHE_DEPTH) - used_q - unused_q;

  // R9: the two queues together never exceed the cache
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, used_q} + {1'b0, unused_q}) <= (CNT_W+1)'(CACHE_DEPTH));

  // R9: a consume with nothing unused leaves used unchanged
  p_take_empty_r9: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (take && unused_q == '0 && !drain) |=> used_q == $past(used_q));
endmodule

// File: rtl/dr_fetch_ctl.sv
module dr_fetch_ctl import dr_pkg::*; #(
  parameter int ADDR_W  = 48,
  parameter int IDX_W   = 12,
  parameter int CNT_W   = 4,
  parameter int DESC_SH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W:0]    len,
  input  logic [IDX_W-1:0]  tail,
  input  logic [CNT_W-1:0]  free_cnt,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CNT_W-1:0]  req_cnt,
  input  logic              done,
  output logic              commit,
  output logic [CNT_W-1:0]  commit_cnt,
  output logic              busy
);
  localparam int LEN_W = IDX_W + 1;

  xfer_st_e          st_q;
  logic [IDX_W-1:0]  cptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  span, nxt;
  logic [CNT_W-1:0]  want;
  logic [ADDR_W-1:0] slot_addr;

  always_comb begin
    if (tail >= cptr_q) span = {1'b0, tail} - {1'b0, cptr_q};
    else                span = len - {1'b0, cptr_q};
    want = (span > LEN_W'(free_cnt)) ? free_cnt : CNT_W'(span);
    nxt  = {1'b0, cptr_q} + LEN_W'(cnt_q);
    slot_addr = base + (ADDR_W'(cptr_q) << DESC_SH);
  end

  assign commit = (st_q == XS_WAIT) && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      cptr_q <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (clr) begin
      st_q   <= XS_IDLE;
      cptr_q <= '0;
    end else begin
      case (st_q)
        XS_IDLE: if (want != '0) begin
          st_q   <= XS_REQ;
          cnt_q  <= want;
          addr_q <= slot_addr;
        end
        XS_REQ:  if (req_ready) st_q <= XS_WAIT;
        XS_WAIT: if (done) begin
          st_q   <= XS_IDLE;
          cptr_q <= (nxt >= len) ? '0 : nxt[IDX_W-1:0];
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  assign req_valid  = (st_q == XS_REQ);
  assign req_addr   = addr_q;
  assign req_cnt    = cnt_q;
  assign commit_cnt = cnt_q;
  assign busy       = (st_q != XS_IDLE);

  // R1: a raised fetch stays inside the ring
  p_no_ring_cross_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({1'b0, cptr_q} + LEN_W'(req_cnt)) <= len);

  // R2: a raised fetch fits the free cache space and is never empty
  p_fit_cache_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_cnt <= free_cnt && req_cnt != '0));

  // R12: an unaccepted request holds still
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_cnt)));

  // R3: the cache pointer moves only on a completed fetch or a clear
  p_cptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cptr_q != $past(cptr_q)) |-> $past(commit || clr));
endmodule

// File: rtl/dr_wb_ctl.sv
module dr_wb_ctl import dr_pkg::*; #(
  parameter int ADDR_W  = 48,
  parameter int IDX_W   = 12,
  parameter int CNT_W   = 4,
  parameter int DESC_SH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W:0]    len,
  input  logic [CNT_W-1:0]  used,
  input  logic              kick,
  input  logic [CNT_W-1:0]  mask,
  input  logic              head_load,
  input  logic [IDX_W-1:0]  head_val,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CNT_W-1:0]  req_cnt,
  input  logic              done,
  output logic              commit,
  output logic [CNT_W-1:0]  commit_cnt,
  output logic              busy,
  output logic [IDX_W-1:0]  head
);
  localparam int LEN_W = IDX_W + 1;

  xfer_st_e          st_q;
  logic [IDX_W-1:0]  head_q;
  logic [CNT_W-1:0]  cnt_q, mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rearm_q;
  logic [LEN_W-1:0]  room, reach, nh;
  logic [CNT_W-1:0]  eff_mask, amount;
  logic              go;

  always_comb begin
    go       = kick || rearm_q;
    eff_mask = kick ? mask : mask_q;
    room     = len - {1'b0, head_q};
    reach    = {1'b0, head_q} + LEN_W'(used);
    if (reach >= len)        amount = CNT_W'(room);
    else if (eff_mask != '0) amount = used & ~eff_mask;
    else                     amount = used;
    nh = {1'b0, head_q} + LEN_W'(cnt_q);
    if (nh >= len) nh = nh - len;
  end

  assign commit = (st_q == XS_WAIT) && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= XS_IDLE;
      head_q  <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      addr_q  <= '0;
      rearm_q <= 1'b0;
    end else if (clr) begin
      st_q    <= XS_IDLE;
      rearm_q <= 1'b0;
      if (head_load) head_q <= head_val;
    end else begin
      if (head_load) head_q <= head_val;
      case (st_q)
        XS_IDLE: if (go) begin
          rearm_q <= 1'b0;
          mask_q  <= eff_mask;
          if (amount != '0) begin
            st_q   <= XS_REQ;
            cnt_q  <= amount;
            addr_q <= base + (ADDR_W'(head_q) << DESC_SH);
          end
        end
        XS_REQ: begin
          if (kick && mask < mask_q) mask_q <= mask;
          if (req_ready) st_q <= XS_WAIT;
        end
        XS_WAIT: begin
          if (kick && mask < mask_q) mask_q <= mask;
          if (done) begin
            st_q    <= XS_IDLE;
            head_q  <= nh[IDX_W-1:0];
            rearm_q <= 1'b1;
          end
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  assign req_valid  = (st_q == XS_REQ);
  assign req_addr   = addr_q;
  assign req_cnt    = cnt_q;
  assign commit_cnt = cnt_q;
  assign busy       = (st_q != XS_IDLE);
  assign head       = head_q;

  // R5: a writeback never passes the ring end nor exceeds what is used
  p_wb_no_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (({1'b0, head_q} + LEN_W'(req_cnt)) <= len && req_cnt <= used));

  // R6: head moves only on a completed writeback or an accepted load
  p_head_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q != $past(head_q)) |-> $past(commit || head_load));

  // R12: an unaccepted writeback request holds still
  p_wb_hold_r12: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_cnt)));
endmodule

// File: rtl/dr_ring_engine.sv
module dr_ring_engine #(
  parameter int ADDR_W      = 48,
  parameter int RING_MAX    = 4096,
  parameter int CACHE_DEPTH = 8,
  parameter int DESC_BYTES  = 16,
  localparam int IDX_W      = $clog2(RING_MAX),
  localparam int CNT_W      = $clog2(CACHE_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_clr,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W:0]    cfg_len,
  input  logic [IDX_W-1:0]  cfg_head,
  input  logic              tail_wr,
  input  logic [IDX_W-1:0]  tail_val,
  input  logic              desc_take,
  input  logic              wb_kick,
  input  logic [CNT_W-1:0]  wb_align_mask,
  output logic              fetch_req_valid,
  input  logic              fetch_req_ready,
  output logic [ADDR_W-1:0] fetch_req_addr,
  output logic [CNT_W-1:0]  fetch_req_cnt,
  input  logic              fetch_done,
  output logic              wb_req_valid,
  input  logic              wb_req_ready,
  output logic [ADDR_W-1:0] wb_req_addr,
  output logic [CNT_W-1:0]  wb_req_cnt,
  input  logic              wb_done,
  output logic [IDX_W-1:0]  head,
  output logic [CNT_W-1:0]  free_cnt,
  output logic [CNT_W-1:0]  used_cnt,
  output logic [CNT_W-1:0]  unused_cnt,
  output logic              cfg_fault
);
  localparam int DESC_SH = $clog2(DESC_BYTES);

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W:0]    len_q;
  logic [IDX_W-1:0]  tail_q;
  logic              fault_q;
  logic              f_commit, w_commit, f_busy, w_busy;
  logic [CNT_W-1:0]  f_commit_cnt, w_commit_cnt;
  logic              engaged, load_ok;

  assign engaged = f_busy || w_busy || (used_cnt != '0) || (unused_cnt != '0);
  assign load_ok = cfg_load && !engaged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      len_q   <= '0;
      tail_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= cfg_load && engaged;
      if (load_ok) begin
        base_q <= cfg_base;
        len_q  <= cfg_len;
      end
      if (tail_wr) tail_q <= tail_val;
    end
  end

  assign cfg_fault = fault_q;

  dr_occupancy #(.CACHE_DEPTH(CACHE_DEPTH), .CNT_W(CNT_W)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ring_clr),
    .fill      (f_commit),
    .fill_cnt  (f_commit_cnt),
    .take      (desc_take),
    .drain     (w_commit),
    .drain_cnt (w_commit_cnt),
    .used      (used_cnt),
    .unused    (unused_cnt),
    .free      (free_cnt)
  );

  dr_fetch_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .DESC_SH(DESC_SH)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (ring_clr),
    .base       (base_q),
    .len        (len_q),
    .tail       (tail_q),
    .free_cnt   (free_cnt),
    .req_valid  (fetch_req_valid),
    .req_ready  (fetch_req_ready),
    .req_addr   (fetch_req_addr),
    .req_cnt    (fetch_req_cnt),
    .done       (fetch_done),
    .commit     (f_commit),
    .commit_cnt (f_commit_cnt),
    .busy       (f_busy)
  );

  dr_wb_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .DESC_SH(DESC_SH)) u_wb (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (ring_clr),
    .base       (base_q),
    .len        (len_q),
    .used       (used_cnt),
    .kick       (wb_kick),
    .mask       (wb_align_mask),
    .head_load  (load_ok),
    .head_val   (cfg_head),
    .req_valid  (wb_req_valid),
    .req_ready  (wb_req_ready),
    .req_addr   (wb_req_addr),
    .req_cnt    (wb_req_cnt),
    .done       (wb_done),
    .commit     (w_commit),
    .commit_cnt (w_commit_cnt),
    .busy       (w_busy),
    .head       (head)
  );

  // R10: a fault pulse always follows a load attempt
  p_fault_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fault |-> $past(cfg_load));

  // R10: ring length stays fixed while a fetch is raised
  p_len_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_valid |=> $stable(len_q));
endmodule

// File: tb/dr_ring_engine_test.sv
module dr_ring_engine_test;
  localparam int ADDR_W = 48;
  localparam int IDX_W  = 12;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ring_clr = 1'b0, cfg_load = 1'b0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [IDX_W:0]    cfg_len = '0;
  logic [IDX_W-1:0]  cfg_head = '0;
  logic              tail_wr = 1'b0;
  logic [IDX_W-1:0]  tail_val = '0;
  logic              desc_take = 1'b0, wb_kick = 1'b0;
  logic [CNT_W-1:0]  wb_align_mask = '0;
  logic              fetch_req_valid, fetch_req_ready = 1'b0, fetch_done = 1'b0;
  logic [ADDR_W-1:0] fetch_req_addr, wb_req_addr;
  logic [CNT_W-1:0]  fetch_req_cnt, wb_req_cnt;
  logic              wb_req_valid, wb_req_ready = 1'b0, wb_done = 1'b0;
  logic [IDX_W-1:0]  head;
  logic [CNT_W-1:0]  free_cnt, used_cnt, unused_cnt;
  logic              cfg_fault;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dr_ring_engine uut (
    .clk(clk), .rst_n(rst_n), .ring_clr(ring_clr), .cfg_load(cfg_load),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_head(cfg_head),
    .tail_wr(tail_wr), .tail_val(tail_val), .desc_take(desc_take),
    .wb_kick(wb_kick), .wb_align_mask(wb_align_mask),
    .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
    .fetch_req_addr(fetch_req_addr), .fetch_req_cnt(fetch_req_cnt),
    .fetch_done(fetch_done), .wb_req_valid(wb_req_valid),
    .wb_req_ready(wb_req_ready), .wb_req_addr(wb_req_addr),
    .wb_req_cnt(wb_req_cnt), .wb_done(wb_done), .head(head),
    .free_cnt(free_cnt), .used_cnt(used_cnt), .unused_cnt(unused_cnt),
    .cfg_fault(cfg_fault)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic take(input int n);
    desc_take = 1'b1;
    for (int i = 0; i < n; i++) step();
    desc_take = 1'b0;
  endtask

  task automatic set_tail(input int t);
    tail_val = IDX_W'(t);
    tail_wr  = 1'b1;
    step();
    tail_wr  = 1'b0;
  endtask

  task automatic kick(input int m);
    wb_align_mask = CNT_W'(m);
    wb_kick = 1'b1;
    step();
    wb_kick = 1'b0;
  endtask

  task automatic fetch_xfer(input string tag, input longint ea, input int ec);
    bit seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (fetch_req_valid) seen = 1'b1;
      else step();
    end
    chk({tag, " fetch raised"}, seen, 1);
    chk({tag, " fetch addr"}, fetch_req_addr, ea);
    chk({tag, " fetch cnt"}, fetch_req_cnt, ec);
    fetch_req_ready = 1'b1;
    step();
    fetch_req_ready = 1'b0;
    fetch_done = 1'b1;
    step();
    fetch_done = 1'b0;
  endtask

  task automatic wb_xfer(input string tag, input longint ea, input int ec);
    bit seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (wb_req_valid) seen = 1'b1;
      else step();
    end
    chk({tag, " wb raised"}, seen, 1);
    chk({tag, " wb addr"}, wb_req_addr, ea);
    chk({tag, " wb cnt"}, wb_req_cnt, ec);
    wb_req_ready = 1'b1;
    step();
    wb_req_ready = 1'b0;
    wb_done = 1'b1;
    step();
    wb_done = 1'b0;
  endtask

  task automatic t_reset();
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R11 reset head", head, 0);
    chk("R11 reset used", used_cnt, 0);
    chk("R11 reset free", free_cnt, 8);
    chk("R11 reset fetch idle", fetch_req_valid, 0);
    chk("R11 reset wb idle", wb_req_valid, 0);
  endtask

  task automatic t_first_fetch();
    cfg_base = 48'h1000; cfg_len = 13'd10; cfg_head = '0;
    cfg_load = 1'b1; step(); cfg_load = 1'b0;
    step();
    chk("R10 clean load no fault", cfg_fault, 0);
    set_tail(5);
    fetch_xfer("R1 R3 tail ahead", 48'h1000, 5);
    chk("R9 unused after fill", unused_cnt, 5);
    chk("R9 free after fill", free_cnt, 3);
  endtask

  task automatic t_wrap_and_cap();
    set_tail(2);
    step();
    chk("R2 cap by free", fetch_req_cnt, 3);
    chk("R1 wrap span addr", fetch_req_addr, 48'h1050);
    fetch_done = 1'b1; step(); fetch_done = 1'b0;
    chk("R12 early done ignored", unused_cnt, 5);
    step();
    chk("R12 held valid", fetch_req_valid, 1);
    chk("R12 held addr", fetch_req_addr, 48'h1050);
    fetch_req_ready = 1'b1; step(); fetch_req_ready = 1'b0;
    set_tail(2); step(); step();
    chk("R4 no second fetch", fetch_req_valid, 0);
    fetch_done = 1'b1; step(); fetch_done = 1'b0;
    chk("R2 unused full", unused_cnt, 8);
    chk("R2 free empty", free_cnt, 0);
  endtask

  task automatic t_consume();
    take(8);
    chk("R9 used after takes", used_cnt, 8);
    chk("R9 unused after takes", unused_cnt, 0);
    take(1);
    chk("R9 take on empty ignored", used_cnt, 8);
    fetch_done = 1'b1; step(); fetch_done = 1'b0;
    chk("R4 stray done ignored", unused_cnt, 0);
    step(); step();
    chk("R2 no fetch when full", fetch_req_valid, 0);
  endtask

  task automatic t_wb_plain();
    kick(0);
    wb_xfer("R5 R6 plain", 48'h1000, 8);
    chk("R6 head advanced", head, 8);
    chk("R6 used drained", used_cnt, 0);
    fetch_xfer("R1 R3 tail end", 48'h1080, 2);
    fetch_xfer("R3 pointer wrapped", 48'h1000, 2);
    chk("R3 unused after two", unused_cnt, 4);
  endtask

  task automatic t_wb_clip();
    take(4);
    kick(1);
    wb_xfer("R5 clip at end", 48'h1080, 2);
    chk("R6 head wraps", head, 0);
    wb_xfer("R7 rearm after clip", 48'h1000, 2);
    chk("R7 head after rearm", head, 2);
    chk("R7 used empty", used_cnt, 0);
  endtask

  task automatic t_wb_align();
    set_tail(9);
    fetch_xfer("R1 R2 long run", 48'h1020, 7);
    take(3);
    kick(1);
    wb_xfer("R5 rounded", 48'h1020, 2);
    step(); step(); step();
    chk("R7 leftover below mask", wb_req_valid, 0);
    chk("R7 head after round", head, 4);
    chk("R7 used left", used_cnt, 1);
    take(1);
    kick(1);
    step();
    chk("R8 first wb cnt", wb_req_cnt, 2);
    chk("R8 first wb addr", wb_req_addr, 48'h1040);
    wb_req_ready = 1'b1; step(); wb_req_ready = 1'b0;
    desc_take = 1'b1; wb_kick = 1'b1; wb_align_mask = '0;
    step();
    desc_take = 1'b0; wb_kick = 1'b0;
    step();
    chk("R8 no second wb", wb_req_valid, 0);
    wb_done = 1'b1; step(); wb_done = 1'b0;
    chk("R6 head after first", head, 6);
    wb_xfer("R8 deferred mask", 48'h1060, 1);
    chk("R8 head final", head, 7);
  endtask

  task automatic t_fault();
    chk("R10 cached before load", unused_cnt, 2);
    cfg_base = 48'h3000; cfg_len = 13'd5; cfg_head = 12'd1;
    cfg_load = 1'b1; step(); cfg_load = 1'b0;
    chk("R10 fault pulse", cfg_fault, 1);
    chk("R10 head kept", head, 7);
    step();
    chk("R10 fault one cycle", cfg_fault, 0);
  endtask

  task automatic t_clear();
    ring_clr = 1'b1; step(); ring_clr = 1'b0;
    chk("R11 clear unused", unused_cnt, 0);
    chk("R11 clear free", free_cnt, 8);
    chk("R11 head survives", head, 7);
    step();
    chk("R11 pointer zero keeps base", fetch_req_addr, 48'h1000);
    chk("R11 refetch cnt", fetch_req_cnt, 8);
    ring_clr = 1'b1; tail_val = '0; tail_wr = 1'b1;
    step();
    ring_clr = 1'b0; tail_wr = 1'b0;
    chk("R11 request dropped", fetch_req_valid, 0);
    step(); step();
    chk("R11 stays quiet", fetch_req_valid, 0);
    cfg_base = 48'h2000; cfg_len = 13'd4; cfg_head = '0;
    cfg_load = 1'b1; step(); cfg_load = 1'b0;
    chk("R10 load after clear", cfg_fault, 0);
    chk("R10 head loaded", head, 0);
    set_tail(3);
    fetch_xfer("R3 new base", 48'h2000, 3);
  endtask

  initial begin
    t_reset();
    t_first_fetch();
    t_wrap_and_cap();
    t_consume();
    t_wb_plain();
    t_wb_clip();
    t_wb_align();
    t_fault();
    t_clear();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL all-requirements watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule